// File: doc/BRIEF.md
# Cascaded Biquad Sample Filter

This block is a recursive filter for a stream of signed samples. It is built from four second-order sections in series. A programmable scale factor sits before the first section, between each pair of sections, and after the last one. Every coefficient and every gain is a 32-bit two's-complement number with 30 fraction bits, so a value can range from -2.0 up to just below +2.0. Each section keeps its own input history and output history, as in direct form 1.

One sample is accepted per input strobe. The result is computed over several clock cycles on a single shared section datapath and a single shared gain datapath. The result appears with a one-cycle output strobe.

With the enable low, the filter is bypassed: a sample is echoed to the output one cycle later and the history is held at zero. A synchronization input zeroes all history at any time and leaves the coefficient inputs untouched.

Top module: `iir_cascade`

## Requirements
- R1: While reset is held, and until the first input strobe after it, `out_valid` is 0 and `out_data` is 0.
- R2: With `enable` low, a sample strobed in at a clock edge appears unchanged on `out_data`, with `out_valid` high, right after the next clock edge.
- R3: With every section set to b0 = 1.0 (0x40000000), all other section taps set to 0, and every gain set to 1.0, an enabled filter returns each input sample unchanged.
- R4: With `enable` high, the result of a sample captured at edge E is presented, with `out_valid` high, right after edge E+9. No new sample may be offered before that.
- R5: Section k computes y = b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. The sum is kept at full width, shifted right arithmetically by 30 (which rounds toward minus infinity), and saturated. Section k's taps b0, b1, b2, a1, a2 occupy 32-bit words 5k to 5k+4 of `sec_coef`, with word w at bits [32w+31:32w].
- R6: Gain word i of `gain_coef` (bits [32i+31:32i]) is applied at chain position i: word 0 before section 0, word i after section i−1, and word 4 after section 3. Each gain product is shifted right by 30 and saturated.
- R7: Every section output and every gain output saturates to the 24-bit range −8388608 to 8388607. This includes the coefficient −2.0 (0x80000000) and the coefficient 0x7FFFFFFF.
- R8: A high `sync_clr` zeroes all section history and abandons any sample in progress. A sample strobed in during that cycle is dropped, and the next result matches a filter that starts from zero history.
- R9: Driving `enable` low for a cycle zeroes all section history, so that after re-enabling the filter responds as if starting from zero history.
- R10: `out_valid` is a single-cycle pulse for each accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = filter active, 0 = bypass with history held at zero |
| sync_clr | input | 1 | Zeroes all history and abandons a sample in progress |
| sec_coef | input | 640 | Section taps, 20 words of 32 bits (b0, b1, b2, a1, a2 for each section) |
| gain_coef | input | 160 | Five 32-bit gains, in chain order |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed filtered sample |

## Verification
The assertions assume three things about the inputs:
- no sample strobe arrives while a result is still being computed;
- the coefficient inputs stay still during a computation;
- reset has passed the internal synchronizer before any strobe.

The bench meets these assumptions in three ways:
- it offers each sample only after the previous result has appeared;
- it changes coefficients only while the filter is idle, followed by a synchronization pulse;
- it waits several cycles after reset before any stimulus.

Expected values come from a floating-point-free integer model of the section equation, kept in the bench.

// File: rtl/iir_pkg.sv
package iir_pkg;
  localparam int COEF_W    = 32;
  localparam int COEF_FRAC = 30;
  localparam int TAPS      = 5;

  typedef enum int {
    TAP_B0 = 0,
    TAP_B1 = 1,
    TAP_B2 = 2,
    TAP_A1 = 3,
    TAP_A2 = 4
  } tap_e;
endpackage

// File: rtl/iir_rst_sync.sv
module iir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/iir_shift_sat.sv
module iir_shift_sat #(
  parameter int IW    = 59,
  parameter int OW    = 24,
  parameter int SHIFT = 30
) (
  input  logic signed [IW-1:0] acc_i,
  output logic signed [OW-1:0] res_o
);
  localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [IW-1:0] shifted;

  always_comb begin
    shifted = acc_i >>> SHIFT;
    if (shifted > HI)      res_o = HI[OW-1:0];
    else if (shifted < LO) res_o = LO[OW-1:0];
    else                   res_o = shifted[OW-1:0];
  end
endmodule

// File: rtl/iir_gain.sv
module iir_gain #(
  parameter int SW   = 24,
  parameter int CW   = 32,
  parameter int FRAC = 30
) (
  input  logic signed [SW-1:0] x_i,
  input  logic signed [CW-1:0] g_i,
  output logic signed [SW-1:0] y_o
);
  localparam int PW = SW + CW;

  logic signed [PW-1:0] prod;

  assign prod = x_i * g_i;

  iir_shift_sat #(.IW(PW), .OW(SW), .SHIFT(FRAC)) u_sat (
    .acc_i(prod),
    .res_o(y_o)
  );
endmodule

// File: rtl/iir_biquad.sv
module iir_biquad #(
  parameter int SW   = 24,
  parameter int CW   = 32,
  parameter int FRAC = 30
) (
  input  logic signed [SW-1:0] x_i,
  input  logic signed [SW-1:0] x1_i,
  input  logic signed [SW-1:0] x2_i,
  input  logic signed [SW-1:0] y1_i,
  input  logic signed [SW-1:0] y2_i,
  input  logic signed [CW-1:0] b0_i,
  input  logic signed [CW-1:0] b1_i,
  input  logic signed [CW-1:0] b2_i,
  input  logic signed [CW-1:0] a1_i,
  input  logic signed [CW-1:0] a2_i,
  output logic signed [SW-1:0] y_o
);
  localparam int AW = SW + CW + 3;

  logic signed [AW-1:0] acc;

  always_comb begin
    acc = b0_i * x_i + b1_i * x1_i + b2_i * x2_i - a1_i * y1_i - a2_i * y2_i;
  end

  iir_shift_sat #(.IW(AW), .OW(SW), .SHIFT(FRAC)) u_sat (
    .acc_i(acc),
    .res_o(y_o)
  );
endmodule

// File: rtl/iir_cascade.sv
module iir_cascade
  import iir_pkg::*;
#(
  parameter int SW   = 24,
  parameter int NSEC = 4,
  parameter int CW   = COEF_W,
  parameter int FRAC = COEF_FRAC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      sync_clr,
  input  logic [NSEC*TAPS*CW-1:0]   sec_coef,
  input  logic [(NSEC+1)*CW-1:0]    gain_coef,
  input  logic                      in_valid,
  input  logic signed [SW-1:0]      in_data,
  output logic                      out_valid,
  output logic signed [SW-1:0]      out_data
);
  localparam int NGAIN = NSEC + 1;
  localparam int NSTEP = 2 * NSEC + 1;
  localparam int STW   = $clog2(NSTEP);
  localparam int HW    = 4 * NSEC * SW;
  localparam logic [STW-1:0] LAST_STEP = STW'(NSTEP - 1);

  logic rst_sync_n;

  logic                 busy_q, busy_d;
  logic [STW-1:0]       step_q, step_d;
  logic signed [SW-1:0] acc_q, acc_d;
  logic                 ov_q, ov_d;
  logic signed [SW-1:0] od_q, od_d;
  logic signed [SW-1:0] x1_q [NSEC];
  logic signed [SW-1:0] x2_q [NSEC];
  logic signed [SW-1:0] y1_q [NSEC];
  logic signed [SW-1:0] y2_q [NSEC];
  logic signed [SW-1:0] x1_d [NSEC];
  logic signed [SW-1:0] x2_d [NSEC];
  logic signed [SW-1:0] y1_d [NSEC];
  logic signed [SW-1:0] y2_d [NSEC];
  logic                 hist_en, core_en, out_en;
  logic [HW-1:0]        hist_flat;

  int                   sec_idx;
  int                   gain_idx;
  logic signed [CW-1:0] tap_b0, tap_b1, tap_b2, tap_a1, tap_a2, gain_sel;
  logic signed [SW-1:0] bq_y, gain_y;

  iir_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // even steps apply gain step/2, odd steps run section step/2
  always_comb begin
    gain_idx = int'(step_q) / 2;
    sec_idx  = (gain_idx < NSEC) ? gain_idx : 0;
    tap_b0   = $signed(sec_coef[(sec_idx*TAPS + TAP_B0)*CW +: CW]);
    tap_b1   = $signed(sec_coef[(sec_idx*TAPS + TAP_B1)*CW +: CW]);
    tap_b2   = $signed(sec_coef[(sec_idx*TAPS + TAP_B2)*CW +: CW]);
    tap_a1   = $signed(sec_coef[(sec_idx*TAPS + TAP_A1)*CW +: CW]);
    tap_a2   = $signed(sec_coef[(sec_idx*TAPS + TAP_A2)*CW +: CW]);
    gain_sel = $signed(gain_coef[((gain_idx < NGAIN) ? gain_idx : 0)*CW +: CW]);
  end

  iir_biquad #(.SW(SW), .CW(CW), .FRAC(FRAC)) u_bq (
    .x_i (acc_q),
    .x1_i(x1_q[sec_idx]),
    .x2_i(x2_q[sec_idx]),
    .y1_i(y1_q[sec_idx]),
    .y2_i(y2_q[sec_idx]),
    .b0_i(tap_b0),
    .b1_i(tap_b1),
    .b2_i(tap_b2),
    .a1_i(tap_a1),
    .a2_i(tap_a2),
    .y_o (bq_y)
  );

  iir_gain #(.SW(SW), .CW(CW), .FRAC(FRAC)) u_gain (
    .x_i(acc_q),
    .g_i(gain_sel),
    .y_o(gain_y)
  );

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    acc_d  = acc_q;
    ov_d   = 1'b0;
    od_d   = od_q;
    for (int k = 0; k < NSEC; k++) begin
      x1_d[k] = x1_q[k];
      x2_d[k] = x2_q[k];
      y1_d[k] = y1_q[k];
      y2_d[k] = y2_q[k];
    end
    if (sync_clr || !enable) begin
      busy_d = 1'b0;
      step_d = '0;
      for (int k = 0; k < NSEC; k++) begin
        x1_d[k] = '0;
        x2_d[k] = '0;
        y1_d[k] = '0;
        y2_d[k] = '0;
      end
      if (in_valid && !enable) begin
        ov_d = 1'b1;
        od_d = in_data;
      end
    end else if (busy_q) begin
      step_d = step_q + 1'b1;
      if (step_q[0]) begin
        acc_d         = bq_y;
        x2_d[sec_idx] = x1_q[sec_idx];
        x1_d[sec_idx] = acc_q;
        y2_d[sec_idx] = y1_q[sec_idx];
        y1_d[sec_idx] = bq_y;
      end else if (step_q == LAST_STEP) begin
        busy_d = 1'b0;
        step_d = '0;
        ov_d   = 1'b1;
        od_d   = gain_y;
      end else begin
        acc_d = gain_y;
      end
    end else if (in_valid) begin
      busy_d = 1'b1;
      step_d = '0;
      acc_d  = in_data;
    end
  end

  assign hist_en = sync_clr | ~enable | (busy_q & step_q[0]);
  assign core_en = busy_q | in_valid | sync_clr | ~enable;
  assign out_en  = ov_d;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      ov_q <= ov_d;
      if (core_en) begin
        busy_q <= busy_d;
        step_q <= step_d;
        acc_q  <= acc_d;
      end
      if (out_en) od_q <= od_d;
    end
  end

  for (genvar k = 0; k < NSEC; k++) begin : g_hist
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        x1_q[k] <= '0;
        x2_q[k] <= '0;
        y1_q[k] <= '0;
        y2_q[k] <= '0;
      end else if (hist_en) begin
        x1_q[k] <= x1_d[k];
        x2_q[k] <= x2_d[k];
        y1_q[k] <= y1_d[k];
        y2_q[k] <= y2_d[k];
      end
    end
    assign hist_flat[k*4*SW +: 4*SW] = {x1_q[k], x2_q[k], y1_q[k], y2_q[k]};
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/iir_cascade_chk.sv
module iir_cascade_chk #(
  parameter int SW   = 24,
  parameter int NSEC = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 sync_clr,
  input logic                 in_valid,
  input logic signed [SW-1:0] in_data,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_data,
  input logic                 busy,
  input logic [4*NSEC*SW-1:0] hist_flat
);
  // R2: bypass echoes the sample one cycle later
  assert_bypass_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !enable) |=> (out_valid && out_data == $past(in_data)));

  // R8 / R9: clearing leaves every history register at zero
  assert_hist_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clr || !enable) |=> (hist_flat == '0));

  // R10: single-cycle strobe unless a fresh bypass sample follows
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(in_valid && !enable)) |=> !out_valid);

  // R4: input protocol, no sample while a result is pending
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && !sync_clr) |-> !in_valid);

  // R4: an output strobe comes from a finished computation or a bypass echo
  assert_valid_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(busy) || $past(in_valid && !enable)));

  // R1: nothing is presented without an earlier strobe
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> !out_valid);
endmodule

bind iir_cascade iir_cascade_chk #(.SW(SW), .NSEC(NSEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .enable   (enable),
  .sync_clr (sync_clr),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data),
  .busy     (busy_q),
  .hist_flat(hist_flat)
);

// File: tb/iir_cascade_test.sv
`timescale 1ns/1ps
module iir_cascade_test;
  localparam int SW = 24;
  localparam int NS = 4;
  localparam int CW = 32;
  localparam longint SMAX = 8388607;
  localparam longint SMIN = -8388608;

  logic clk, rst_n, enable, sync_clr, in_valid, out_valid;
  logic signed [SW-1:0] in_data, out_data;
  logic [NS*5*CW-1:0] sec_coef;
  logic [(NS+1)*CW-1:0] gain_coef;

  int signed cb [NS][5];
  int signed cg [NS+1];
  longint mx1 [NS], mx2 [NS], my1 [NS], my2 [NS];

  int checks = 0;
  int fails  = 0;

  iir_cascade uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_clr(sync_clr),
    .sec_coef(sec_coef), .gain_coef(gain_coef),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NS; k++)
      for (int j = 0; j < 5; j++)
        sec_coef[(k*5+j)*CW +: CW] = cb[k][j];
    for (int i = 0; i < NS+1; i++)
      gain_coef[i*CW +: CW] = cg[i];
  end

  function automatic longint sat_sh(longint a);
    longint s;
    s = a >>> 30;
    if (s > SMAX) return SMAX;
    if (s < SMIN) return SMIN;
    return s;
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < NS; k++) begin
      mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
    end
  endfunction

  function automatic longint model(longint x);
    longint v, y;
    v = sat_sh(x * longint'(cg[0]));
    for (int k = 0; k < NS; k++) begin
      y = sat_sh(longint'(cb[k][0]) * v + longint'(cb[k][1]) * mx1[k]
               + longint'(cb[k][2]) * mx2[k] - longint'(cb[k][3]) * my1[k]
               - longint'(cb[k][4]) * my2[k]);
      mx2[k] = mx1[k]; mx1[k] = v;
      my2[k] = my1[k]; my1[k] = y;
      v = sat_sh(y * longint'(cg[k+1]));
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_unity();
    for (int k = 0; k < NS; k++) begin
      cb[k][0] = 32'h40000000;
      for (int j = 1; j < 5; j++) cb[k][j] = 0;
    end
    for (int i = 0; i < NS+1; i++) cg[i] = 32'h40000000;
  endtask

  task automatic pulse_clear();
    @(negedge clk); sync_clr = 1'b1;
    @(negedge clk); sync_clr = 1'b0;
    model_clear();
  endtask

  // enabled sample: result expected right after the 10th edge
  task automatic run_sample(input longint v, input string req, output longint got);
    longint exp;
    exp = model(v);
    @(negedge clk); in_valid = 1'b1; in_data = SW'(v);
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (8) @(posedge clk);
    #1 check(out_valid == 1'b0, {req, " early"}, out_valid, 0);
    @(posedge clk); #1;
    check(out_valid == 1'b1, {req, " valid"}, out_valid, 1);
    check(longint'(out_data) == exp, req, out_data, exp);
    got = out_data;
  endtask

  task automatic t_reset();
    #1 check(out_valid == 1'b0 && out_data == '0, "R1", out_data, 0);
  endtask

  task automatic t_bypass();
    longint vals [3] = '{123456, -8388608, 8388607};
    enable = 1'b0;
    foreach (vals[i]) begin
      @(negedge clk); in_valid = 1'b1; in_data = SW'(vals[i]);
      @(posedge clk); #1 in_valid = 1'b0;
      check(out_valid == 1'b1 && longint'(out_data) == vals[i], "R2", out_data, vals[i]);
    end
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic t_unity();
    longint got;
    longint vals [3] = '{77, -4000000, 8388607};
    set_unity(); pulse_clear();
    foreach (vals[i]) begin
      run_sample(vals[i], "R3", got);
      check(got == vals[i], "R3 identity", got, vals[i]);
    end
  endtask

  task automatic t_pulse();
    longint got;
    run_sample(1000, "R4", got);
    @(posedge clk); #1 check(out_valid == 1'b0, "R10", out_valid, 0);
  endtask

  task automatic t_general();
    longint got;
    longint seq [10] = '{1000000, 0, 0, 0, 200000, 200000, 200000, 200000, -3000000, -3000000};
    cb[0] = '{32'h20000000, 32'h20000000, 0, 32'hE0000000, 0};
    cb[1] = '{32'h40000000, 32'hC0000000, 32'h10000000, 32'h10000000, 32'hF8000000};
    cb[2] = '{32'h30000000, 0, 0, 0, 32'h10000000};
    cb[3] = '{32'h40000000, 0, 32'h20000000, 0, 0};
    cg    = '{32'h20000000, 32'h60000000, 32'h40000000, 32'h30000000, 32'h50000000};
    pulse_clear();
    foreach (seq[i]) run_sample(seq[i], "R5", got);
  endtask

  task automatic t_order();
    longint got;
    set_unity();
    cg[0] = 32'h70000000; cg[NS] = 32'h10000000;
    pulse_clear();
    run_sample(8000000, "R6", got);
    check(got == 2097151, "R6 gain order", got, 2097151);
    set_unity(); cg[0] = 32'h20000000; pulse_clear();
    run_sample(-5, "R5 floor", got);
    check(got == -3, "R5 floor value", got, -3);
  endtask

  task automatic t_sat();
    longint got;
    set_unity(); cb[0][0] = 32'h7FFFFFFF; pulse_clear();
    run_sample(8000000, "R7", got);
    check(got == SMAX, "R7 high", got, SMAX);
    pulse_clear();
    run_sample(-8000000, "R7", got);
    check(got == SMIN, "R7 low", got, SMIN);
    set_unity(); cb[2][0] = 32'h80000000; pulse_clear();
    run_sample(-8388608, "R7", got);
    check(got == SMAX, "R7 minus two", got, SMAX);
  endtask

  task automatic t_sync();
    longint got;
    bit seen;
    t_general_coefs();
    pulse_clear();
    run_sample(2000000, "R8 prime", got);
    run_sample(-1500000, "R8 prime", got);
    @(negedge clk); sync_clr = 1'b1; in_valid = 1'b1; in_data = 24'sd999;
    @(negedge clk); sync_clr = 1'b0; in_valid = 1'b0;
    seen = 1'b0;
    repeat (12) begin @(posedge clk); #1 if (out_valid) seen = 1'b1; end
    check(!seen, "R8 dropped", seen, 0);
    model_clear();
    run_sample(1000000, "R8", got);
    run_sample(0, "R8", got);
    run_sample(0, "R8", got);
  endtask

  task automatic t_general_coefs();
    cb[0] = '{32'h20000000, 32'h20000000, 0, 32'hE0000000, 0};
    cb[1] = '{32'h40000000, 0, 0, 32'hD0000000, 32'h08000000};
    cb[2] = '{32'h40000000, 0, 0, 0, 0};
    cb[3] = '{32'h40000000, 32'h20000000, 0, 0, 0};
    cg    = '{32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000};
  endtask

  task automatic t_disable();
    longint got;
    t_general_coefs();
    pulse_clear();
    run_sample(3000000, "R9 prime", got);
    run_sample(3000000, "R9 prime", got);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    model_clear();
    run_sample(500000, "R9", got);
    run_sample(0, "R9", got);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; sync_clr = 1'b0;
    in_valid = 1'b0; in_data = '0;
    set_unity(); model_clear();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_bypass();
    t_unity();
    t_pulse();
    t_general();
    t_order();
    t_sat();
    t_sync();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule